// File: doc/BRIEF.md
# Serial Register Row Loader

This block is the configuration port of a radio chip, on the device side. It watches a three-wire serial bus: an active-low select, a serial clock and a data line. It collects one 18-bit write frame each time the select is held low. When the select goes high again and the frame is well formed, the block writes one 8-bit row of a 16-row configuration array. The core clock runs several times faster than the serial clock. It passes every serial line through a two-flop synchronizer and finds the edges in its own domain.

The full array, 128 bits, is driven onto a flat parallel bus that the rest of the chip reads directly. Each committed row also gives a single-cycle strobe and the index of that row, so that consumers can react to the change. Frames that are malformed or addressed to another device leave the array untouched.

Top module: `cfg_row_port`

## Requirements
- R1: Row r of the array appears on `regs_flat[8r+7:8r]` for r = 0..15.
- R2: The frame is 18 bits, sent in this order, one bit on each rising serial clock edge while the select is low. Bits 0..7 are the row data, least significant bit first. Bits 8..13 are a 6-bit row address, least significant bit first. Bit 14 is the write flag. Bits 15..17 are the device address, least significant bit first, and must equal binary 110 (bit 15 = 0, bit 16 = 1, bit 17 = 1).
- R3: The low four address bits choose the row that is written.
- R4: The array does not change while the select is low. A row is written only after the select rises.
- R5: A frame with a bit count other than 18 is discarded.
- R6: A frame whose device address is not 110 is discarded.
- R7: A frame whose write flag is 0 is discarded.
- R8: A frame whose two upper address bits are not both zero is discarded.
- R9: Each committed write raises `wr_stb` for exactly one core cycle, with `wr_row` equal to the row written. Discarded frames give no strobe.
- R10: A synchronous reset clears every row to zero, clears the frame bit counter and holds `wr_stb` low.
- R11: Each falling edge of the select restarts the bit count, so an aborted frame has no effect on the frame that follows it.
- R12: A write changes only the addressed row. All other rows keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial lines |
| rst | input | 1 | Synchronous reset, active high |
| ser_sel_n | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| regs_flat | output | 128 | Whole array, row r at bits 8r+7:8r |
| wr_stb | output | 1 | One-cycle pulse for each committed row |
| wr_row | output | 4 | Index of the row just committed |

## Verification
Well-formed writes are sent to the first row, the last row and a middle row, with data patterns that alternate, fill and sparsely set bits. A repeated write to the same row shows that the old value is overwritten and that the other rows are left alone. Frames of 17 and 19 bits, a wrong device address, a cleared write flag and a set upper address bit each differ from a valid frame in only one field, so each one exercises a single discard condition. An aborted 10-bit frame followed by a good one checks the restart of the bit count. A check of the array just before the select rises confirms that no write happens early.

// File: rtl/cfg_row_pkg.sv
package cfg_row_pkg;
    localparam int ROWS_DEF   = 16;
    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W_DEF = 6;
    localparam int CHIP_W_DEF = 3;
    localparam logic [CHIP_W_DEF-1:0] CHIP_ID_DEF = 3'b110;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        typedef struct packed {
            logic meta;
            logic stab;
        } sync_t;
        sync_t st_d, st_q;

        always_comb begin
            st_d.meta = async_i[i];
            st_d.stab = st_q.meta;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= '{meta: RST_VAL[i], stab: RST_VAL[i]};
            end else begin
                st_q <= st_d;
            end
        end

        assign sync_o[i] = st_q.stab;
    end
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int SEL_W  = 4,
    parameter int CHIP_W = 3,
    parameter logic [CHIP_W-1:0] CHIP_ID = 3'b110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              commit,
    output logic [SEL_W-1:0]  commit_row,
    output logic [DATA_W-1:0] commit_data
);
    localparam int FRAME_BITS = DATA_W + ADDR_W + 1 + CHIP_W;
    localparam int RW_POS     = DATA_W + ADDR_W;
    localparam int CHIP_LSB   = RW_POS + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    typedef struct packed {
        logic                  sel;
        logic                  sck;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sh;
    } rx_t;

    rx_t rx_d, rx_q;
    logic sel_fall, sel_rise, sck_rise, frame_ok;

    always_comb begin
        rx_d     = rx_q;
        rx_d.sel = sel_n;
        rx_d.sck = sck;
        sel_fall = rx_q.sel & ~sel_n;
        sel_rise = ~rx_q.sel & sel_n;
        sck_rise = ~rx_q.sck & sck;

        if (sel_fall) begin
            rx_d.cnt = '0;
            rx_d.sh  = '0;
        end else if (!sel_n && sck_rise) begin
            rx_d.sh = {sdi, rx_q.sh[FRAME_BITS-1:1]};
            if (rx_q.cnt != CNT_SAT) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end

        frame_ok = (rx_q.cnt == CNT_FULL)
                 && rx_q.sh[RW_POS]
                 && (rx_q.sh[FRAME_BITS-1:CHIP_LSB] == CHIP_ID)
                 && (rx_q.sh[RW_POS-1:DATA_W+SEL_W] == '0);

        commit      = sel_rise & frame_ok;
        commit_row  = rx_q.sh[DATA_W+SEL_W-1:DATA_W];
        commit_data = rx_q.sh[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '{sel: 1'b1, sck: 1'b0, cnt: '0, sh: '0};
        end else begin
            rx_q <= rx_d;
        end
    end
endmodule

// File: rtl/cfg_row_bank.sv
module cfg_row_bank #(
    parameter int ROWS   = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [SEL_W-1:0]         we_row,
    input  logic [DATA_W-1:0]        we_data,
    output logic [ROWS*DATA_W-1:0]   flat_o,
    output logic                     stb_o,
    output logic [SEL_W-1:0]         row_o
);
    typedef struct packed {
        logic [ROWS-1:0][DATA_W-1:0] rows;
        logic                        stb;
        logic [SEL_W-1:0]            row;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d     = bk_q;
        bk_d.stb = we;
        if (we) begin
            bk_d.row          = we_row;
            bk_d.rows[we_row] = we_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign flat_o = bk_q.rows;
    assign stb_o  = bk_q.stb;
    assign row_o  = bk_q.row;
endmodule

// File: rtl/cfg_row_port.sv
module cfg_row_port
    import cfg_row_pkg::*;
#(
    parameter int ROWS   = ROWS_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int CHIP_W = CHIP_W_DEF,
    parameter logic [CHIP_W-1:0] CHIP_ID = CHIP_ID_DEF,
    localparam int SEL_W = $clog2(ROWS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ser_sel_n,
    input  logic                   ser_clk,
    input  logic                   ser_dat,
    output logic [ROWS*DATA_W-1:0] regs_flat,
    output logic                   wr_stb,
    output logic [SEL_W-1:0]       wr_row
);
    logic [2:0]        lines_s;
    logic              commit;
    logic [SEL_W-1:0]  commit_row;
    logic [DATA_W-1:0] commit_data;

    cfg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i({ser_sel_n, ser_clk, ser_dat}),
        .sync_o (lines_s)
    );

    cfg_frame_rx #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W),
        .CHIP_W (CHIP_W),
        .CHIP_ID(CHIP_ID)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .sel_n      (lines_s[2]),
        .sck        (lines_s[1]),
        .sdi        (lines_s[0]),
        .commit     (commit),
        .commit_row (commit_row),
        .commit_data(commit_data)
    );

    cfg_row_bank #(.ROWS(ROWS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (commit),
        .we_row (commit_row),
        .we_data(commit_data),
        .flat_o (regs_flat),
        .stb_o  (wr_stb),
        .row_o  (wr_row)
    );
endmodule

// File: rtl/cfg_row_port_chk.sv
module cfg_row_port_chk #(
    parameter int ROWS   = 16,
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(ROWS),
    localparam int FLAT  = ROWS * DATA_W
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_sel_n,
    input logic [FLAT-1:0]  regs_flat,
    input logic             wr_stb,
    input logic [SEL_W-1:0] wr_row
);
    logic [FLAT-1:0] row_mask;
    always_comb row_mask = {{(FLAT-DATA_W){1'b0}}, {DATA_W{1'b1}}} << (wr_row * DATA_W);

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R4
    hold_without_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |-> $stable(regs_flat));

    // R12
    only_row_changes_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (((regs_flat ^ $past(regs_flat)) & ~row_mask) == '0));

    // R4
    commit_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ser_sel_n);

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (regs_flat == '0 && !wr_stb));
endmodule

bind cfg_row_port cfg_row_port_chk #(.ROWS(ROWS), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_sel_n(ser_sel_n),
    .regs_flat(regs_flat),
    .wr_stb   (wr_stb),
    .wr_row   (wr_row)
);

// File: tb/cfg_row_port_tb.sv
module cfg_row_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_sel_n = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_dat = 1'b0;
    logic [127:0] regs_flat;
    logic         wr_stb;
    logic [3:0]   wr_row;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_row_port u_dut (
        .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .regs_flat(regs_flat), .wr_stb(wr_stb), .wr_row(wr_row)
    );

    function automatic logic [127:0] model_flat();
        logic [127:0] f;
        for (int r = 0; r < 16; r++) f[r*8 +: 8] = model[r];
        return f;
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] d, input logic [5:0] a,
                                       input logic rw, input logic [2:0] chip);
        return {14'd0, chip, rw, a, d};
    endfunction

    task automatic check_vec(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_hold();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] bits, input int n, output int nstb,
                        output logic [3:0] row);
        nstb = 0;
        row  = '0;
        @(negedge clk);
        ser_sel_n = 1'b0;
        wait_hold();
        for (int i = 0; i < n; i++) begin
            ser_dat = bits[i];
            wait_hold();
            ser_clk = 1'b1;
            wait_hold();
            ser_clk = 1'b0;
        end
        repeat (6) @(negedge clk);
        // R4: nothing written while select is still low
        check_vec("R4 before select rise", regs_flat, model_flat());
        ser_sel_n = 1'b1;
        ser_dat   = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (wr_stb) begin
                nstb++;
                row = wr_row;
            end
        end
    endtask

    task automatic t_write(input logic [7:0] d, input logic [3:0] r, input string tag);
        int ns;
        logic [3:0] rr;
        send(mk(d, {2'b00, r}, 1'b1, 3'b110), 18, ns, rr);
        model[r] = d;
        check_vec({tag, " R1 R2 R3 R12 array contents"}, regs_flat, model_flat());
        check_int({tag, " R9 strobe count"}, ns, 1);
        check_int({tag, " R3 R9 strobe row"}, int'(rr), int'(r));
    endtask

    task automatic t_reject(input logic [31:0] bits, input int n, input string tag);
        int ns;
        logic [3:0] rr;
        send(bits, n, ns, rr);
        check_vec({tag, " array unchanged"}, regs_flat, model_flat());
        check_int({tag, " R9 no strobe"}, ns, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 16; r++) model[r] = '0;
        check_vec("R10 rows cleared", regs_flat, '0);
        check_int("R10 strobe low", int'(wr_stb), 0);
    endtask

    task automatic t_abort_then_good();
        t_reject(mk(8'h3C, 6'd5, 1'b1, 3'b110), 10, "R11 R5 aborted frame");
        t_write(8'hC3, 4'd5, "R11 frame after abort");
    endtask

    initial begin
        for (int r = 0; r < 16; r++) model[r] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_vec("R10 reset state", regs_flat, '0);
        check_int("R10 reset strobe", int'(wr_stb), 0);

        t_write(8'hA5, 4'd3, "write row 3");
        t_write(8'hFF, 4'd0, "write row 0");
        t_write(8'h01, 4'd15, "write row 15");
        t_write(8'h5A, 4'd3, "overwrite row 3");

        t_reject(mk(8'h77, 6'd7, 1'b1, 3'b110), 17, "R5 17 bits");
        t_reject({13'd0, 1'b0, mk(8'h77, 6'd7, 1'b1, 3'b110)}, 19, "R5 19 bits");
        t_reject(mk(8'h77, 6'd7, 1'b1, 3'b010), 18, "R6 wrong device");
        t_reject(mk(8'h77, 6'd7, 1'b1, 3'b111), 18, "R6 device 111");
        t_reject(mk(8'h77, 6'd7, 1'b0, 3'b110), 18, "R7 read flag");
        t_reject(mk(8'h77, 6'b010111, 1'b1, 3'b110), 18, "R8 upper addr bit");
        t_reject(mk(8'h77, 6'b100111, 1'b1, 3'b110), 18, "R8 top addr bit");

        t_abort_then_good();
        t_write(8'h80, 4'd9, "sparse write row 9");

        t_reset();
        t_write(8'h42, 4'd12, "write after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule